// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block watches for a stalled program. A free-running prescaler divides the system clock. Its selected tap advances a two-bit tick counter. When the tick counter wraps past its fourth tick, the watchdog has overflowed. Software prevents the overflow by writing one exact key byte to the clear register. Any other byte has no effect.

A control register holds a response bit and a two-bit period field. In interrupt mode, an overflow gives a one-cycle interrupt request and counting carries on. In reset mode, an overflow starts a reset request pulse of fixed length. The watchdog is held idle while that pulse lasts. Both registers are written through a plain address/data/strobe port.

Top module: `keyed_watchdog`

## Requirements
- R1: While `rst_n` is low, and after it is released, both outputs are low, the response bit is 1 (reset mode) and the period field is binary 11. The first overflow therefore comes 2^(BASE_SHIFT+8) clocks after release, and it raises `wdt_rst`.
- R2: The control register is at address 0. Bits [1:0] form the period field `p` and bit 2 is the response bit (0 = interrupt, 1 = reset). An overflow comes 2^(BASE_SHIFT+2+2p) clocks after the last restart: 2^13, 2^15, 2^17 or 2^19 clocks at the default BASE_SHIFT of 11. A write to the control register does not restart counting.
- R3: Writing 0x4E to the clear register at address 1 restarts the prescaler and the tick counter from zero. The next overflow is then one full period after that write.
- R4: Any other byte written to the clear register, and any write to addresses 2 or 3, leaves the count unchanged. The pending overflow keeps its original time.
- R5: In interrupt mode, an overflow drives `wdt_irq` high for exactly one cycle, beginning the cycle after the overflow. `wdt_rst` stays low.
- R6: In interrupt mode, counting wraps to zero after an overflow. Further interrupt pulses follow, one full period apart.
- R7: In reset mode, an overflow drives `wdt_rst` high for exactly PULSE_LEN (24) consecutive cycles, beginning the cycle after the overflow. `wdt_irq` stays low.
- R8: While `wdt_rst` is high, the counters are held at zero and register writes are ignored. The control register returns to reset mode with period 11. Counting restarts when the pulse ends.
- R9: A key write in the same cycle as an overflow wins. No interrupt or reset request is produced, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address (0 control, 1 clear) |
| wr_data | input | DW | Write data |
| wdt_irq | output | 1 | One-cycle interrupt request |
| wdt_rst | output | 1 | Reset request pulse |

## Verification
The bench measures each period to the exact clock, so an off-by-one tap, or a prescaler that is not cleared by the key, shows up as a wrong count. It sends non-key bytes and writes to other addresses in the middle of a count. A design that cleared on any write to the clear register would fire late. It places a key write exactly on the overflow cycle; a design without key priority would emit a stray interrupt. During a reset pulse it writes interrupt mode, a short period and the key. A design that accepted those writes would shorten the pulse or fire early afterwards.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int DW = 8,
  parameter int AW = 2,
  parameter int BASE_SHIFT = 11,
  parameter int PULSE_LEN = 24,
  parameter logic [7:0] KEY = 8'h4E,
  parameter int CTRL_ADDR = 0,
  parameter int CLR_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wdt_irq,
  output logic          wdt_rst
);
  localparam int PW = BASE_SHIFT + 6;
  localparam int RW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] pre_q;
  logic [1:0]    tick_q;
  logic [1:0]    sel_q;
  logic          mode_q;
  logic [RW-1:0] pulse_q;
  logic          irq_q;

  logic [PW-1:0] tap_mask;
  logic          tick, pulsing, key_hit, ctrl_wr, ovf;

  assign tap_mask = {PW{1'b1}} >> (6 - 2 * int'(sel_q));
  assign tick     = &(pre_q | ~tap_mask);
  assign pulsing  = pulse_q != '0;
  assign key_hit  = wr_en && !pulsing && wr_addr == AW'(CLR_ADDR) && wr_data == DW'(KEY);
  assign ctrl_wr  = wr_en && !pulsing && wr_addr == AW'(CTRL_ADDR);
  assign ovf      = tick && tick_q == 2'd3 && !key_hit && !pulsing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      tick_q  <= '0;
      sel_q   <= 2'b11;
      mode_q  <= 1'b1;
      pulse_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (pulsing || key_hit) begin
        pre_q  <= '0;
        tick_q <= '0;
      end else begin
        pre_q <= pre_q + 1'b1;
        if (tick) tick_q <= tick_q + 1'b1;
      end

      if (pulsing) begin
        sel_q  <= 2'b11;
        mode_q <= 1'b1;
      end else if (ctrl_wr) begin
        sel_q  <= wr_data[1:0];
        mode_q <= wr_data[2];
      end

      if (ovf && mode_q) pulse_q <= RW'(PULSE_LEN);
      else if (pulsing)  pulse_q <= pulse_q - 1'b1;

      irq_q <= ovf && !mode_q;
    end
  end

  assign wdt_irq = irq_q;
  assign wdt_rst = pulsing;
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int DW = 8,
  parameter int AW = 2,
  parameter int PULSE_LEN = 24,
  parameter logic [7:0] KEY = 8'h4E,
  parameter int CLR_ADDR = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          wdt_irq,
  input logic          wdt_rst,
  input logic          mode_q,
  input logic [1:0]    sel_q
);
  logic [15:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= '0;
    else if (wdt_rst) run_len <= run_len + 1'b1;
    else              run_len <= '0;
  end

  // R5
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |=> !wdt_irq);

  // R5
  irq_rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_irq && wdt_rst));

  // R7
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= 16'(PULSE_LEN));

  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst) |-> run_len == 16'(PULSE_LEN));

  // R8
  defaults_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst) |-> (mode_q && sel_q == 2'b11));

  // R9
  key_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdt_rst && wr_addr == AW'(CLR_ADDR) && wr_data == DW'(KEY))
      |=> (!wdt_irq && !wdt_rst));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(
  .DW(DW), .AW(AW), .PULSE_LEN(PULSE_LEN), .KEY(KEY), .CLR_ADDR(CLR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wdt_irq(wdt_irq), .wdt_rst(wdt_rst), .mode_q(mode_q), .sel_q(sel_q)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
  localparam int B = 3;
  localparam int PL = 24;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wdt_irq, wdt_rst;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  keyed_watchdog #(.BASE_SHIFT(B), .PULSE_LEN(PL)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wdt_irq(wdt_irq), .wdt_rst(wdt_rst));

  function automatic int period(int p);
    return 1 << (B + 2 + 2 * p);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // counts edges until irq or rst is seen; kind 1 = irq, 2 = rst, 0 = none
  task automatic wait_evt(output int n, output int kind, input int limit);
    n = 0; kind = 0;
    while (n < limit) begin
      @(negedge clk); n++;
      if (wdt_irq) begin kind = 1; return; end
      if (wdt_rst) begin kind = 2; return; end
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", int'(wdt_irq), 0);
    check("R1 rst in reset", int'(wdt_rst), 0);
    rst_n = 1;
  endtask

  task automatic t_reset_default();
    int n, k, len;
    do_reset();
    wait_evt(n, k, 5000);
    check("R1 first overflow time", n, period(3));
    check("R1 reset response", k, 2);
    len = 1;
    while (wdt_rst && len < 100) begin @(negedge clk); if (wdt_rst) len++; end
    check("R7 pulse length", len, PL);
    wait_evt(n, k, 5000);
    check("R8 restart after pulse", n, period(3));
    check("R8 kind after pulse", k, 2);
    while (wdt_rst) @(negedge clk);
  endtask

  task automatic t_pulse_writes();
    int n, k, len;
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h4E);
    wait_evt(n, k, 5000);
    check("R2 reset mode p=0 time", n, period(0));
    check("R7 reset mode kind", k, 2);
    len = 1;
    repeat (5) begin @(negedge clk); if (wdt_rst) len++; end
    wr(2'd0, 8'h00); if (wdt_rst) len++;
    wr(2'd1, 8'h4E); if (wdt_rst) len++;
    while (wdt_rst && len < 100) begin @(negedge clk); if (wdt_rst) len++; end
    check("R8 writes do not shorten pulse", len, PL);
    wait_evt(n, k, 5000);
    check("R8 defaults restored period", n, period(3));
    check("R8 defaults restored mode", k, 2);
    while (wdt_rst) @(negedge clk);
  endtask

  task automatic t_irq_periods();
    int n, k;
    for (int p = 0; p < 4; p++) begin
      wr(2'd0, 8'(p));
      wr(2'd1, 8'h4E);
      wait_evt(n, k, 5000);
      check($sformatf("R2 period p=%0d", p), n, period(p));
      check("R5 irq response", k, 1);
      @(negedge clk);
      check("R5 irq one cycle", int'(wdt_irq), 0);
      check("R5 no reset", int'(wdt_rst), 0);
      wait_evt(n, k, 5000);
      check($sformatf("R6 repeat p=%0d", p), n + 1, period(p));
    end
  endtask

  task automatic t_key_restart();
    int n, k;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h4E);
    repeat (20) @(negedge clk);
    wr(2'd1, 8'h4E);
    wait_evt(n, k, 5000);
    check("R3 key restarts count", n, period(0));
    check("R3 kind", k, 1);
  endtask

  task automatic t_nonkey();
    int n, k;
    wr(2'd1, 8'h4E);
    repeat (10) @(negedge clk);
    wr(2'd1, 8'h4D);
    wr(2'd2, 8'h4E);
    wr(2'd3, 8'h4E);
    wr(2'd1, 8'h00);
    wait_evt(n, k, 5000);
    check("R4 non-key ignored", n, period(0) - 14);
    check("R4 kind", k, 1);
  endtask

  task automatic t_key_on_overflow();
    int n, k;
    wr(2'd1, 8'h4E);
    repeat (period(0) - 1) @(negedge clk);
    check("R9 no early irq", int'(wdt_irq), 0);
    wr(2'd1, 8'h4E);
    check("R9 no irq on key cycle", int'(wdt_irq), 0);
    wait_evt(n, k, 5000);
    check("R9 count restarted", n, period(0));
    check("R9 kind", k, 1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset_default();
    t_pulse_writes();
    t_irq_periods();
    t_key_restart();
    t_nonkey();
    t_key_on_overflow();
    finish_run();
  end
endmodule